// File: doc/BRIEF.md
# Ethernet MAC Frame Status Latch

This block sits beside an Ethernet MAC and keeps per-frame status where software can read it. On the receive side, the receiver sends one-cycle event pulses (an internal parity fault, FIFO overflow and other per-frame conditions), one pulse lane per condition. Each lane sets a sticky flag. The flags stay set until the next frame begins, and then they clear by themselves; reading them does not clear them. A per-flag enable register and one global mask bit decide whether a set flag drives the level-sensitive receive interrupt.

On the transmit side, the MAC presents a live 16-bit status word. A completion pulse copies that word into a shadow register. The shadow then stays frozen until the next completion, so software can read a stable copy of it. Software reaches the flags, the enable register, the global mask register and the transmit shadow over a small synchronous write / combinational read register bus.

Receive tracking is a two-state machine. `RX_QUIET` means no flag is set. `RX_HELD` means at least one flag is set. The transitions are:
- `QUIET_TO_HELD`: any event pulse.
- `HELD_TO_QUIET`: a frame start with no event in the same cycle.
- `HELD_STAY`: any other cycle while held, including a frame start together with an event.

Top module: `fsl_status_latch`

## Requirements
- R1: An event pulse on lane i sets receive flag bit i on the next clock edge. Lane 0 is the internal receive parity-error lane and maps to flag bit 0.
- R2: A set receive flag stays set on every cycle without a frame-start pulse, whatever software does on the bus.
- R3: A frame-start pulse replaces the flags on the next edge with that cycle's event lanes. With no event, all flags clear. An event in the same cycle as the start wins, so its flag is set for the new frame.
- R4: `irq_rx` is high exactly when (flags AND enable) is nonzero and bit 13 of the global mask register is 0. It is combinational and level-sensitive, so it drops as soon as the flags clear or the mask bit is set.
- R5: On a `tx_done` pulse, the transmit shadow takes `tx_status_live` on the next edge, with an identical bit layout.
- R6: Without `tx_done`, the transmit shadow holds its value.
- R7: Register map, with `reg_rdata` combinational from `reg_addr`:
  - address 0: receive flags (bit i = lane i, zero-extended, read-only).
  - address 1: receive enable (low NUM_EVT bits, read/write).
  - address 2: global mask (16 bits, read/write).
  - address 3: transmit shadow (read-only).
  - addresses 4 to 7: read as 0.
  A write (`reg_wr` high) takes effect on the next edge.
- R8: Writes to addresses 0 and 3 change no state.
- R9: While `rst_n` is low, all registers are 0 and `irq_rx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_frame_start | input | 1 | One-cycle pulse: a new received frame begins |
| rx_event | input | NUM_EVT | One-cycle event pulses, one per status condition |
| tx_done | input | 1 | One-cycle pulse: a transmission completed |
| tx_status_live | input | 16 | Live transmit status word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_rx | output | 1 | Receive interrupt, level |

## Verification
The bench aims at a frame start in the same cycle as an event. A design that let the clear win would show an empty flag word for a frame that already had an error. It writes all ones to the read-only flag and shadow addresses: a design that decoded those writes would corrupt status that software relies on. It toggles mask bit 13 while enabled flags are set, and changes the live transmit word between completions. This catches an interrupt that ignores the global mask, and a shadow that tracks the live word instead of freezing.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_RX_FLAGS = 3'd0;
    localparam logic [ADDR_W-1:0] A_RX_EN    = 3'd1;
    localparam logic [ADDR_W-1:0] A_GMASK    = 3'd2;
    localparam logic [ADDR_W-1:0] A_TX_SHAD  = 3'd3;

    typedef enum logic {
        RX_QUIET = 1'b0,
        RX_HELD  = 1'b1
    } rx_state_e;
endpackage

// File: rtl/fsl_rx_flags.sv
module fsl_rx_flags
    import fsl_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [NUM_EVT-1:0] event_in,
    output logic [NUM_EVT-1:0] flags
);
    rx_state_e          state_q, state_d;
    logic [NUM_EVT-1:0] flags_q, flags_d;
    logic               any_evt;

    assign any_evt = |event_in;

    // State register and flag storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_QUIET;
            flags_q <= '0;
        end else begin
            state_q <= state_d;
            flags_q <= flags_d;
        end
    end

    // Next state and flag update
    always_comb begin
        state_d = state_q;
        flags_d = flags_q;
        unique case (state_q)
            RX_QUIET: begin
                flags_d = event_in;
                if (any_evt) state_d = RX_HELD;
            end
            RX_HELD: begin
                if (frame_start) begin
                    flags_d = event_in;
                    if (!any_evt) state_d = RX_QUIET;
                end else begin
                    flags_d = flags_q | event_in;
                end
            end
            default: begin
                state_d = RX_QUIET;
                flags_d = '0;
            end
        endcase
    end

    assign flags = flags_q;

    p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(event_in)) == $past(event_in)));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (flags_q == $past(event_in)));

    p_state_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_QUIET) == (flags_q == '0));
endmodule

// File: rtl/fsl_tx_shadow.sv
module fsl_tx_shadow
    import fsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] live,
    output logic [DATA_W-1:0] shadow
);
    logic [DATA_W-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    shadow_q <= '0;
        else if (done) shadow_q <= live;
    end

    assign shadow = shadow_q;

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (shadow_q == $past(live)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(shadow_q));
endmodule

// File: rtl/fsl_regbank.sv
module fsl_regbank
    import fsl_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_EVT-1:0] flags,
    input  logic [DATA_W-1:0]  tx_shadow,
    output logic [NUM_EVT-1:0] enable,
    output logic [DATA_W-1:0]  gmask,
    output logic [DATA_W-1:0]  rdata
);
    logic [NUM_EVT-1:0] en_q;
    logic [DATA_W-1:0]  mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
        end else if (wr) begin
            if (addr == A_RX_EN) en_q   <= wdata[NUM_EVT-1:0];
            if (addr == A_GMASK) mask_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_RX_FLAGS: rdata[NUM_EVT-1:0] = flags;
            A_RX_EN:    rdata[NUM_EVT-1:0] = en_q;
            A_GMASK:    rdata = mask_q;
            A_TX_SHAD:  rdata = tx_shadow;
            default:    rdata = '0;
        endcase
    end

    assign enable = en_q;
    assign gmask  = mask_q;

    p_ro_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == A_RX_FLAGS || addr == A_TX_SHAD)) |=> ($stable(en_q) && $stable(mask_q)));

    p_rw_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_GMASK) |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/fsl_status_latch.sv
module fsl_status_latch
    import fsl_pkg::*;
#(
    parameter int NUM_EVT  = 8,
    parameter int MASK_BIT = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_frame_start,
    input  logic [NUM_EVT-1:0] rx_event,
    input  logic               tx_done,
    input  logic [15:0]        tx_status_live,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    output logic               irq_rx
);
    logic [NUM_EVT-1:0] flags;
    logic [NUM_EVT-1:0] enable;
    logic [DATA_W-1:0]  gmask;
    logic [DATA_W-1:0]  shadow;

    fsl_rx_flags #(.NUM_EVT(NUM_EVT)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(rx_frame_start),
        .event_in   (rx_event),
        .flags      (flags)
    );

    fsl_tx_shadow u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (tx_done),
        .live  (tx_status_live),
        .shadow(shadow)
    );

    fsl_regbank #(.NUM_EVT(NUM_EVT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .flags    (flags),
        .tx_shadow(shadow),
        .enable   (enable),
        .gmask    (gmask),
        .rdata    (reg_rdata)
    );

    assign irq_rx = (|(flags & enable)) & ~gmask[MASK_BIT];

    p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gmask[MASK_BIT] |-> !irq_rx);

    p_irq_noflag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq_rx);

    always_comb begin
        if (!rst_n) p_reset_quiet_r9: assert (!irq_rx || $isunknown(irq_rx));
    end
endmodule

// File: tb/fsl_status_latch_tb.sv
`timescale 1ns/1ps
module fsl_status_latch_tb;
    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_frame_start = 1'b0;
    logic [NE-1:0] rx_event = '0;
    logic        tx_done = 1'b0;
    logic [15:0] tx_status_live = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_rx;

    always #2.5 clk = ~clk;

    fsl_status_latch #(.NUM_EVT(NE), .MASK_BIT(13)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_frame_start(rx_frame_start),
        .rx_event(rx_event), .tx_done(tx_done), .tx_status_live(tx_status_live),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_rx(irq_rx)
    );

    // Behavioural reference state
    int unsigned m_flags = 0, m_en = 0, m_mask = 0, m_shadow = 0;
    bit ro_wr_last = 0;
    int checks = 0, fails = 0;
    bit finished = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (rx_frame_start) m_flags = rx_event;
            else                m_flags = m_flags | rx_event;
            if (reg_wr && reg_addr == 1) m_en = reg_wdata & 8'hFF;
            if (reg_wr && reg_addr == 2) m_mask = reg_wdata;
            if (tx_done) m_shadow = tx_status_live;
            ro_wr_last = reg_wr && (reg_addr == 0 || reg_addr == 3);
        end
    end

    task automatic compare(input string force_tag);
        int unsigned exp_rd;
        bit exp_irq;
        string tag;
        case (reg_addr)
            3'd0: exp_rd = m_flags;
            3'd1: exp_rd = m_en;
            3'd2: exp_rd = m_mask;
            3'd3: exp_rd = m_shadow;
            default: exp_rd = 0;
        endcase
        exp_irq = ((m_flags & m_en) != 0) && !m_mask[13];
        if (force_tag != "") tag = force_tag;
        else if (ro_wr_last && (reg_addr == 0 || reg_addr == 3)) tag = "R8";
        else if (reg_addr == 0) tag = "R1/R2/R3";
        else if (reg_addr == 3) tag = "R5/R6";
        else tag = "R7";
        checks++;
        if (reg_rdata !== exp_rd[15:0]) begin
            fails++;
            $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, reg_addr, reg_rdata, exp_rd[15:0]);
        end
        checks++;
        if (irq_rx !== exp_irq) begin
            fails++;
            $display("FAIL %s irq_rx actual=%b expected=%b", (force_tag != "") ? force_tag : "R4", irq_rx, exp_irq);
        end
    endtask

    task automatic cyc(input bit st, input logic [NE-1:0] ev, input bit dn,
                       input logic [15:0] live, input bit wr,
                       input logic [2:0] a, input logic [15:0] wd);
        @(negedge clk);
        compare("");
        rx_frame_start = st; rx_event = ev; tx_done = dn;
        tx_status_live = live; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    endtask

    initial begin
        // R9: reset state, checked while reset is held
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            reg_addr = 3'(a);
            #0.5;
            compare("R9");
        end
        @(negedge clk);
        rst_n = 1'b1;
        // enable all flags, clear mask
        cyc(0, 0, 0, 16'h0, 1, 3'd1, 16'hFFFF);
        cyc(0, 0, 0, 16'h0, 1, 3'd2, 16'h0000);
        // R1: parity lane sets flag 0
        cyc(0, 8'h01, 0, 16'h0, 0, 3'd0, 16'h0);
        cyc(0, 0, 0, 16'h0, 0, 3'd0, 16'h0);
        // R2: held across idle cycles and another event
        cyc(0, 8'h10, 0, 16'h0, 0, 3'd0, 16'h0);
        cyc(0, 0, 0, 16'h0, 0, 3'd0, 16'h0);
        // R3: start alone clears
        cyc(1, 0, 0, 16'h0, 0, 3'd0, 16'h0);
        cyc(0, 0, 0, 16'h0, 0, 3'd0, 16'h0);
        // R3: start with event, event wins
        cyc(0, 8'h02, 0, 16'h0, 0, 3'd0, 16'h0);
        cyc(1, 8'h04, 0, 16'h0, 0, 3'd0, 16'h0);
        cyc(0, 0, 0, 16'h0, 0, 3'd0, 16'h0);
        // R8: writes to read-only addresses
        cyc(0, 0, 0, 16'h0, 1, 3'd0, 16'hFFFF);
        cyc(0, 0, 0, 16'h0, 0, 3'd0, 16'h0);
        cyc(0, 0, 0, 16'h0, 0, 3'd1, 16'h0);
        // R4: global mask bit 13 blocks interrupt
        cyc(0, 0, 0, 16'h0, 1, 3'd2, 16'h2000);
        cyc(0, 0, 0, 16'h0, 0, 3'd2, 16'h0);
        cyc(0, 0, 0, 16'h0, 1, 3'd2, 16'hDFFF);
        cyc(0, 0, 0, 16'h0, 0, 3'd0, 16'h0);
        // R5/R6: transmit shadow
        cyc(0, 0, 1, 16'hA5C3, 0, 3'd3, 16'h0);
        cyc(0, 0, 0, 16'h1234, 0, 3'd3, 16'h0);
        cyc(0, 0, 0, 16'h5678, 1, 3'd3, 16'hFFFF);
        cyc(0, 0, 0, 16'h0, 0, 3'd3, 16'h0);
        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[3:0] == 0, NE'($urandom & $urandom & $urandom),
                r[6:4] == 0, 16'($urandom), r[9:7] == 0,
                3'($urandom), (r[10] ? 16'($urandom) : (r[11] ? 16'h2000 : 16'h0)));
        end
        cyc(0, 0, 0, 16'h0, 0, 3'd0, 16'h0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule